// File: doc/BRIEF.md
# Multiplexed Address-Latch Byte Memory

This block is the device-side front end of a byte-wide nonvolatile memory whose low address byte and data share one 8-bit bus. A strobe captures the low address from the shared bus on its falling edge. The upper address bits arrive on dedicated inputs. Stored bytes are returned onto the shared bus under an active-low output enable. The device has no chip enable. Its operating state comes from the strobe level, the output-enable level and two digital flags. The flags stand for high voltage on the output-enable pin and on the identification address pin.

The storage is a behavioural register array. A write can only pull bits from 1 to 0. The first write sends the device into a verify state that only the synchronous reset can leave; the reset stands in for power-down. The bus is split into an input byte, an output byte and a drive enable, so a pad ring can build the three-state pin. All outputs are registered, and each result appears one clock after the inputs that cause it are sampled.

Top module: `mux_addr_mem`

## Requirements
- R1: At a clock edge where the strobe `ale` is sampled low after being sampled high in the previous cycle, with `hv_oe` low, `bus_in` is stored as the low address byte. At no other edge does the low address change.
- R2: With `oe_n` low, `ale` low, `hv_oe` low and no identification request, `bus_en` is 1 one cycle later and `bus_out` holds the byte at address {`addr_hi`, latched low byte}. Bytes that were never written read 0xFF.
- R3: With `ale` low and `oe_n` high (output disable), `bus_en` is 0 one cycle later.
- R4: With `ale` high (standby when `oe_n` is also high), `bus_en` is 0 one cycle later, whatever the level of `oe_n`.
- R5: With `hv_oe` high and `hv_id` low, a falling strobe edge writes `bus_in` to the latched address. That edge does not reload the low address, and the bus is never driven while `hv_oe` is high.
- R6: A write stores the old byte AND the written byte, so no bit goes from 0 to 1.
- R7: After the first write, the device stays in verify state until reset. In that state reads return the array contents even when `hv_id` is high.
- R8: Outside verify state, with `hv_id` high and the read conditions of R2 met, `bus_out` is 0xDA when `addr_hi[0]` is 0 and 0x1F when it is 1.
- R9: `rst` clears `bus_en`, the verify state and the latched low byte to zero. The array contents are kept.
- R10: A falling strobe edge with both `hv_oe` and `hv_id` high writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, models power-down |
| ale | input | 1 | Address latch strobe, low byte captured on its fall |
| oe_n | input | 1 | Output enable, active low |
| hv_oe | input | 1 | High voltage present on the output-enable pin (write mode) |
| hv_id | input | 1 | High voltage present on the identification address pin |
| addr_hi | input | HI_W | Upper address bits, bit 0 selects the identification byte |
| bus_in | input | 8 | Shared bus, incoming side (low address or write data) |
| bus_out | output | 8 | Shared bus, outgoing data |
| bus_en | output | 1 | Drive enable for the shared bus |

## Verification
Inputs are driven on the falling clock edge. Every bus result (drive enable and data) is due at the first rising edge after those inputs and stays until the next one. The driver task tags each expected item with that cycle number, and the monitor compares it on the following falling edge. A low-address capture or an array write also takes effect at one rising edge, so every read that follows is issued at least one cycle later. It is then scored under the same one-cycle rule.

// File: rtl/mam_pkg.sv
package mam_pkg;
   typedef enum logic [2:0] {
      MAM_READ,
      MAM_IDENT,
      MAM_OFF,
      MAM_STBY,
      MAM_PROG
   } mam_mode_e;

   localparam logic [7:0] MAM_ID_EVEN = 8'hDA;
   localparam logic [7:0] MAM_ID_ODD  = 8'h1F;

   function automatic logic [7:0] mam_merge(input logic [7:0] old_b, input logic [7:0] new_b);
      return old_b & new_b;
   endfunction
endpackage

// File: rtl/mam_addr_latch.sv
module mam_addr_latch #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ale,
   input  logic              hv_oe,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] lo_q,
   output logic              fall
);
   logic ale_q;

   assign fall = ale_q & ~ale;

   always_ff @(posedge clk) begin
      if (rst) begin
         ale_q <= 1'b0;
         lo_q  <= '0;
      end else begin
         ale_q <= ale;
         if (fall && !hv_oe) lo_q <= bus_in;
      end
   end
endmodule

// File: rtl/mam_mode_decode.sv
module mam_mode_decode
   import mam_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      ale,
   input  logic      oe_n,
   input  logic      hv_oe,
   input  logic      hv_id,
   input  logic      fall,
   output mam_mode_e mode,
   output logic      wr_en,
   output logic      verify_q
);
   always_comb begin
      wr_en = 1'b0;
      if (hv_oe) begin
         mode  = MAM_PROG;
         wr_en = fall & ~hv_id;
      end else if (ale) begin
         mode = MAM_STBY;
      end else if (oe_n) begin
         mode = MAM_OFF;
      end else if (hv_id && !verify_q) begin
         mode = MAM_IDENT;
      end else begin
         mode = MAM_READ;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) verify_q <= 1'b0;
      else if (wr_en) verify_q <= 1'b1;
   end
endmodule

// File: rtl/mam_cell_array.sv
module mam_cell_array
   import mam_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 8,
   parameter bit STORE_INVERT = 1'b1
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   generate
      if (STORE_INVERT) begin : g_inv
         // cells hold the complement: an all-zero cell reads as erased
         assign rd_data = ~cells[addr];
         always_ff @(posedge clk) begin
            if (wr_en) cells[addr] <= ~mam_merge(~cells[addr], wr_data);
         end
      end else begin : g_true
         assign rd_data = cells[addr];
         always_ff @(posedge clk) begin
            if (wr_en) cells[addr] <= mam_merge(cells[addr], wr_data);
         end
      end
   endgenerate
endmodule

// File: rtl/mux_addr_mem.sv
module mux_addr_mem
   import mam_pkg::*;
#(
   parameter int HI_W         = 4,
   parameter int DATA_W       = 8,
   parameter bit STORE_INVERT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ale,
   input  logic              oe_n,
   input  logic              hv_oe,
   input  logic              hv_id,
   input  logic [HI_W-1:0]   addr_hi,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_en
);
   localparam int ADDR_W = HI_W + DATA_W;

   generate
      if (DATA_W != 8) begin : g_bad_dw
         $error("mux_addr_mem: DATA_W must be 8");
      end
      if (HI_W < 1 || HI_W > 8) begin : g_bad_hw
         $error("mux_addr_mem: HI_W must be 1..8");
      end
   endgenerate

   logic [DATA_W-1:0] lo_addr;
   logic              fall;
   mam_mode_e         mode;
   logic              wr_en;
   logic              verify_q;
   logic [DATA_W-1:0] rd_data;
   logic [DATA_W-1:0] id_byte;

   mam_addr_latch #(.DATA_W(DATA_W)) u_latch (
      .clk(clk), .rst(rst), .ale(ale), .hv_oe(hv_oe),
      .bus_in(bus_in), .lo_q(lo_addr), .fall(fall)
   );

   mam_mode_decode u_mode (
      .clk(clk), .rst(rst), .ale(ale), .oe_n(oe_n), .hv_oe(hv_oe),
      .hv_id(hv_id), .fall(fall), .mode(mode), .wr_en(wr_en),
      .verify_q(verify_q)
   );

   mam_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STORE_INVERT(STORE_INVERT)) u_cells (
      .clk(clk), .wr_en(wr_en), .addr({addr_hi, lo_addr}),
      .wr_data(bus_in), .rd_data(rd_data)
   );

   assign id_byte = addr_hi[0] ? MAM_ID_ODD : MAM_ID_EVEN;

   always_ff @(posedge clk) begin
      if (rst) begin
         bus_en  <= 1'b0;
         bus_out <= '0;
      end else begin
         bus_en <= (mode == MAM_READ) || (mode == MAM_IDENT);
         if (mode == MAM_IDENT)     bus_out <= id_byte;
         else if (mode == MAM_READ) bus_out <= rd_data;
      end
   end
endmodule

module mam_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              ale,
   input logic              oe_n,
   input logic              hv_oe,
   input logic [DATA_W-1:0] bus_in,
   input logic              bus_en,
   input logic [DATA_W-1:0] lo_q,
   input logic              verify
);
   assert_lo_capture_R1: assert property (@(posedge clk) disable iff (rst)
      ($past(ale, 2) && !$past(ale) && !$past(hv_oe) && !$past(rst) && !$past(rst, 2))
      |-> (lo_q == $past(bus_in)));

   assert_lo_hold_R1: assert property (@(posedge clk) disable iff (rst)
      (!($past(ale, 2) && !$past(ale) && !$past(hv_oe)) && !$past(rst))
      |-> $stable(lo_q));

   assert_off_hiz_R3: assert property (@(posedge clk) disable iff (rst)
      $past(oe_n) |-> !bus_en);

   assert_stby_hiz_R4: assert property (@(posedge clk) disable iff (rst)
      $past(ale) |-> !bus_en);

   assert_prog_hiz_R5: assert property (@(posedge clk) disable iff (rst)
      $past(hv_oe) |-> !bus_en);

   assert_verify_sticky_R7: assert property (@(posedge clk) disable iff (rst)
      ($past(verify) && !$past(rst)) |-> verify);
endmodule

bind mux_addr_mem mam_checker #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst(rst), .ale(ale), .oe_n(oe_n), .hv_oe(hv_oe),
   .bus_in(bus_in), .bus_en(bus_en), .lo_q(lo_addr), .verify(verify_q)
);

// File: tb/mux_addr_mem_test.sv
module mux_addr_mem_test;
   logic       clk = 1'b0;
   logic       rst;
   logic       ale, oe_n, hv_oe, hv_id;
   logic [3:0] addr_hi;
   logic [7:0] bus_in;
   logic [7:0] bus_out;
   logic       bus_en;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   typedef struct {
      int         due;
      logic       en;
      logic [7:0] d;
      string      tag;
   } exp_t;
   exp_t q[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   mux_addr_mem #(.HI_W(4)) uut (
      .clk(clk), .rst(rst), .ale(ale), .oe_n(oe_n), .hv_oe(hv_oe),
      .hv_id(hv_id), .addr_hi(addr_hi), .bus_in(bus_in),
      .bus_out(bus_out), .bus_en(bus_en)
   );

   // monitor: score every item whose due cycle has been reached
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].due <= cyc) begin
         exp_t e;
         e = q.pop_front();
         total++;
         if (e.en) begin
            if (!(bus_en && bus_out == e.d)) begin
               bad++;
               $display("FAIL %s: en=%0b data=%02h expected en=1 data=%02h", e.tag, bus_en, bus_out, e.d);
            end
         end else if (bus_en) begin
            bad++;
            $display("FAIL %s: en=1 expected en=0", e.tag);
         end
      end
   end

   task automatic tick();
      @(negedge clk);
   endtask

   // inputs already set at this negedge; result due after next rising edge
   task automatic expect_bus(input logic en, input logic [7:0] d, input string tag);
      exp_t e;
      e.due = cyc + 1; e.en = en; e.d = d; e.tag = tag;
      q.push_back(e);
      tick();
   endtask

   task automatic latch(input logic [7:0] lo);
      oe_n = 1'b1; bus_in = lo; ale = 1'b1;
      tick();
      ale = 1'b0;
      tick();
   endtask

   task automatic rd(input logic [3:0] hi, input logic [7:0] d, input string tag);
      addr_hi = hi; oe_n = 1'b0; ale = 1'b0;
      expect_bus(1'b1, d, tag);
      oe_n = 1'b1;
   endtask

   task automatic prog(input logic [7:0] d);
      hv_oe = 1'b1; oe_n = 1'b0; bus_in = d; ale = 1'b1;
      tick();
      ale = 1'b0;
      expect_bus(1'b0, 8'h00, "R5 no drive in write mode");
      tick();
      hv_oe = 1'b0; oe_n = 1'b1;
      tick();
   endtask

   initial begin
      rst = 1'b1; ale = 1'b0; oe_n = 1'b1; hv_oe = 1'b0; hv_id = 1'b0;
      addr_hi = 4'd0; bus_in = 8'h00;
      repeat (3) tick();
      total++;
      if (bus_en !== 1'b0) begin bad++; $display("FAIL R9 reset: en=%0b expected 0", bus_en); end
      rst = 1'b0;
      tick();

      // R2 erased read
      latch(8'h5A);
      rd(4'd3, 8'hFF, "R2 erased byte");
      // R3 output disable
      ale = 1'b0; oe_n = 1'b1;
      expect_bus(1'b0, 8'h00, "R3 output disable");
      // R4 standby and strobe-high with oe low
      ale = 1'b1; oe_n = 1'b1;
      expect_bus(1'b0, 8'h00, "R4 standby");
      ale = 1'b1; oe_n = 1'b0; bus_in = 8'h5A;
      expect_bus(1'b0, 8'h00, "R4 strobe high");
      ale = 1'b0; oe_n = 1'b1; tick();

      // R8 identification bytes
      hv_id = 1'b1;
      rd(4'd2, 8'hDA, "R8 id even");
      rd(4'd3, 8'h1F, "R8 id odd");
      hv_id = 1'b0;

      // R10 no write with both flags
      latch(8'h5A); addr_hi = 4'd2;
      hv_id = 1'b1; prog(8'h00); hv_id = 1'b0;
      rd(4'd2, 8'hFF, "R10 blocked write");

      // R5 write, R1 no relatch during write, R6 AND merge
      latch(8'h5A); addr_hi = 4'd3;
      prog(8'hC3);
      rd(4'd3, 8'hC3, "R5 written byte at unchanged low address R1");
      addr_hi = 4'd3; prog(8'h3C);
      rd(4'd3, 8'h00, "R6 AND of C3 and 3C");
      rd(4'd2, 8'hFF, "R5 other page untouched");
      latch(8'h11);
      rd(4'd3, 8'hFF, "R1 new low address");
      latch(8'h5A);
      rd(4'd3, 8'h00, "R1 relatched low address");

      // R7 verify state overrides identification
      hv_id = 1'b1;
      rd(4'd3, 8'h00, "R7 verify returns array");
      hv_id = 1'b0;

      // R9 reset leaves verify, keeps contents
      rst = 1'b1; tick(); tick();
      total++;
      if (bus_en !== 1'b0) begin bad++; $display("FAIL R9 reset drive: en=%0b expected 0", bus_en); end
      rst = 1'b0; tick();
      rd(4'd3, 8'hFF, "R9 low byte cleared to 00");
      hv_id = 1'b1;
      rd(4'd2, 8'hDA, "R9 id back after reset");
      hv_id = 1'b0;
      latch(8'h5A);
      rd(4'd3, 8'h00, "R9 contents kept");

      repeat (3) tick();
      if (q.size() != 0) begin
         total++; bad++;
         $display("FAIL scoreboard: %0d items left expected 0", q.size());
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: run hung, cycles=%0d expected finish", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule